// File: doc/BRIEF.md
# Idle Mode Core Clock Controller

This block puts a microcontroller core into a low-power idle state and brings it back out. Software writes a one-bit idle request through a small register port. The core clock enable then drops at the next machine-cycle boundary. The peripheral clock enable stays high, so timers, serial units and converters keep running and can raise the interrupt that ends idle. While the core enable is low, the core register file, its memories and its port outputs see no enable, so none of them can change.

Two kinds of event end idle. The first is an enabled interrupt, which needs both its source enable bit and the global enable. The second is a supervisor reset request from low-voltage detect, the debug port or the external reset pin. Either event clears the idle bit in hardware. An interrupt restores the core enable at the next machine-cycle boundary, and the core resumes where it stopped. A supervisor reset restores the enable at once and holds the core in reset for a fixed number of whole machine cycles. The watchdog request cannot end idle. It acts as a restart source only while the core enable is on. All enables are registered outputs, so the clock tree never sees a gated clock.

Top module: `idle_clk_ctrl`

## Requirements
- R1: While rst_n is low, core_ce=1, core_rst=0, idle_active=0, ctl_rbit=0 and periph_ce=0.
- R2: A cycle with ctl_we=1 loads ctl_wbit into the idle bit, and ctl_rbit shows the new value from the next cycle on.
- R3: A machine cycle is MC_CLKS clocks (default 4). Boundary edges fall every MC_CLKS rising edges, counted from reset release or from the last supervisor reset edge. When the idle bit's next value is 1 at a boundary edge, core_ce falls at that edge. core_ce changes only at boundary edges or supervisor reset edges.
- R4: periph_ce goes high at the first edge after reset release and stays high, including throughout idle.
- R5: An interrupt wake is any bit set in irq_req & irq_en while gie=1. It clears the idle bit at the next edge, and core_ce returns at the following boundary edge.
- R6: A pending request whose source enable is 0, or any request while gie=0, leaves the idle bit set and core_ce low.
- R7: A request on rst_lvd, rst_dbg or rst_ext clears the idle bit and sets core_ce at the next edge. It restarts machine-cycle timing, and core_rst stays high for exactly RESTART_MC*MC_CLKS clocks (default 12) after the last request cycle.
- R8: rst_wdt while core_ce=0 has no effect: the idle bit stays set, core_ce stays 0 and core_rst stays 0.
- R9: rst_wdt while core_ce=1 acts like the other supervisor requests and starts the same restart hold.
- R10: If a wake event and a write of 1 to the idle bit fall in the same cycle, the wake wins and the bit reads 0.
- R11: idle_active is high exactly while core_ce is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wbit | input | 1 | Value written to the idle bit |
| ctl_rbit | output | 1 | Current idle bit |
| irq_req | input | NUM_IRQ | Per-source interrupt requests |
| irq_en | input | NUM_IRQ | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| rst_lvd | input | 1 | Low-voltage detect reset request |
| rst_dbg | input | 1 | Debug port reset request |
| rst_ext | input | 1 | External pin reset request |
| rst_wdt | input | 1 | Watchdog reset request |
| core_ce | output | 1 | Core clock enable |
| periph_ce | output | 1 | Peripheral clock enable |
| core_rst | output | 1 | Core reset hold |
| idle_active | output | 1 | High while the core enable is gated |

## Verification
The properties assume that every request and enable input is synchronous to clk and is sampled only at rising edges. They also assume that software does not write the idle bit in the same cycle as a wake it expects to win. That case belongs to R10, so the property that the bit holds excludes write cycles. The stimulus changes every input on the falling edge and holds reset requests for single cycles. The bench starts each timed case with an external reset pulse, so machine-cycle phase is known from the requirements alone.

// File: rtl/idle_clk_ctrl.sv
module idle_clk_ctrl #(
  parameter int MC_CLKS    = 4,
  parameter int NUM_IRQ    = 8,
  parameter int RESTART_MC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic               ctl_wbit,
  output logic               ctl_rbit,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               gie,
  input  logic               rst_lvd,
  input  logic               rst_dbg,
  input  logic               rst_ext,
  input  logic               rst_wdt,
  output logic               core_ce,
  output logic               periph_ce,
  output logic               core_rst,
  output logic               idle_active
);
  localparam int MCW = (MC_CLKS > 1) ? $clog2(MC_CLKS) : 1;
  localparam int RCW = $clog2(RESTART_MC + 1);

  logic [MCW-1:0] mc_cnt;
  logic [RCW-1:0] rst_cnt;
  logic           idle_bit;

  wire mc_end   = (mc_cnt == MCW'(MC_CLKS - 1));
  wire irq_wake = gie & |(irq_req & irq_en);
  wire sup_req  = rst_lvd | rst_dbg | rst_ext | (rst_wdt & core_ce);
  wire idle_nxt = (sup_req | irq_wake) ? 1'b0 : (ctl_we ? ctl_wbit : idle_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_cnt    <= '0;
      rst_cnt   <= '0;
      idle_bit  <= 1'b0;
      core_ce   <= 1'b1;
      periph_ce <= 1'b0;
    end else begin
      periph_ce <= 1'b1;
      idle_bit  <= idle_nxt;
      if (sup_req) begin
        mc_cnt  <= '0;
        rst_cnt <= RCW'(RESTART_MC);
        core_ce <= 1'b1;
      end else begin
        mc_cnt <= mc_end ? '0 : mc_cnt + MCW'(1);
        if (mc_end) begin
          core_ce <= ~idle_nxt;
          if (rst_cnt != '0) rst_cnt <= rst_cnt - RCW'(1);
        end
      end
    end
  end

  assign core_rst    = (rst_cnt != '0);
  assign idle_active = ~core_ce;
  assign ctl_rbit    = idle_bit;
endmodule

// File: rtl/idle_clk_ctrl_chk.sv
module idle_clk_ctrl_chk #(
  parameter int MC_CLKS = 4,
  parameter int NUM_IRQ = 8,
  localparam int MCW = (MC_CLKS > 1) ? $clog2(MC_CLKS) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ctl_we,
  input logic               idle_rd,
  input logic [NUM_IRQ-1:0] irq_req,
  input logic [NUM_IRQ-1:0] irq_en,
  input logic               gie,
  input logic               rst_lvd,
  input logic               rst_dbg,
  input logic               rst_ext,
  input logic               rst_wdt,
  input logic               core_ce,
  input logic               periph_ce,
  input logic               core_rst,
  input logic [MCW-1:0]     mc_cnt
);
  logic pin_rst, wake;
  assign pin_rst = rst_lvd | rst_dbg | rst_ext;
  assign wake    = gie & |(irq_req & irq_en);

  a_r4_periph_on: assert property (@(posedge clk) disable iff (!rst_n)
    periph_ce |=> periph_ce);

  a_r3_ce_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(core_ce) |-> ($past(mc_cnt) == MCW'(MC_CLKS - 1) || $past(pin_rst) || $past(rst_wdt && core_ce)));

  a_r5_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !idle_rd);

  a_r6_masked_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_rd && !wake && !pin_rst && !(rst_wdt && core_ce) && !ctl_we) |=> idle_rd);

  a_r7_pin_restart: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rst |=> (core_rst && core_ce && !idle_rd));

  a_r8_wdt_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_wdt && !core_ce && !core_rst && !pin_rst) |=> !core_rst);
endmodule

bind idle_clk_ctrl idle_clk_ctrl_chk #(.MC_CLKS(MC_CLKS), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .idle_rd(ctl_rbit),
  .irq_req(irq_req), .irq_en(irq_en), .gie(gie),
  .rst_lvd(rst_lvd), .rst_dbg(rst_dbg), .rst_ext(rst_ext), .rst_wdt(rst_wdt),
  .core_ce(core_ce), .periph_ce(periph_ce), .core_rst(core_rst), .mc_cnt(mc_cnt)
);

// File: tb/test_idle_clk_ctrl.sv
`timescale 1ns/1ps
module test_idle_clk_ctrl;
  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, ctl_wbit = 0, gie = 0;
  logic rst_lvd = 0, rst_dbg = 0, rst_ext = 0, rst_wdt = 0;
  logic [7:0] irq_req = '0, irq_en = '0;
  logic ctl_rbit, core_ce, periph_ce, core_rst, idle_active;
  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  idle_clk_ctrl i_idle_clk_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wbit(ctl_wbit), .ctl_rbit(ctl_rbit),
    .irq_req(irq_req), .irq_en(irq_en), .gie(gie),
    .rst_lvd(rst_lvd), .rst_dbg(rst_dbg), .rst_ext(rst_ext), .rst_wdt(rst_wdt),
    .core_ce(core_ce), .periph_ce(periph_ce), .core_rst(core_rst), .idle_active(idle_active));

  // fields: irq[22:15] en[14:7] gie[6] lvd[5] dbg[4] ext[3] wdt[2] wake[1] rst[0]
  localparam logic [22:0] VEC [9] = '{
    {8'h01, 8'h01, 1'b1, 4'b0000, 2'b10},
    {8'h80, 8'h80, 1'b1, 4'b0000, 2'b10},
    {8'h01, 8'h02, 1'b1, 4'b0000, 2'b00},
    {8'h01, 8'h01, 1'b0, 4'b0000, 2'b00},
    {8'h00, 8'h00, 1'b0, 4'b1000, 2'b11},
    {8'h00, 8'h00, 1'b0, 4'b0100, 2'b11},
    {8'h00, 8'h00, 1'b0, 4'b0010, 2'b11},
    {8'h00, 8'h00, 1'b0, 4'b0001, 2'b00},
    {8'h00, 8'hFF, 1'b1, 4'b0000, 2'b00}
  };

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic align();
    rst_ext = 1; @(negedge clk); rst_ext = 0;
    repeat (12) @(negedge clk);
  endtask

  task automatic enter_idle();
    align();
    ctl_we = 1; ctl_wbit = 1; @(negedge clk); ctl_we = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic count_rst(output int n);
    n = 0;
    while (core_rst && n < 40) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 core_ce", core_ce, 1); chk("R1 core_rst", core_rst, 0);
    chk("R1 idle_active", idle_active, 0); chk("R1 ctl_rbit", ctl_rbit, 0);
    chk("R1 periph_ce", periph_ce, 0);
    rst_n = 1; @(negedge clk);
    chk("R4 periph_ce after reset", periph_ce, 1);

    for (int i = 0; i < 9; i++) begin
      logic [22:0] v;
      v = VEC[i];
      enter_idle();
      chk("R3 gated in table", core_ce, 0);
      {irq_req, irq_en, gie, rst_lvd, rst_dbg, rst_ext, rst_wdt} = v[22:2];
      @(negedge clk);
      {irq_req, irq_en, gie, rst_lvd, rst_dbg, rst_ext, rst_wdt} = '0;
      repeat (3) @(negedge clk);
      chk(v[1] ? "R5/R7 wake bit" : "R6/R8 stay bit", ctl_rbit, !v[1]);
      chk(v[1] ? "R5/R7 wake ce" : "R6/R8 stay ce", core_ce, v[1]);
      chk("R11 idle_active", idle_active, !v[1]);
      chk("R4 periph_ce in idle", periph_ce, 1);
      chk(v[0] ? "R7 restart hold" : "R8 no restart", core_rst, v[0]);
      repeat (14) @(negedge clk);
    end

    // R3: write on a boundary cycle gates at that boundary
    align();
    repeat (3) @(negedge clk);
    chk("R3 before boundary", core_ce, 1);
    ctl_we = 1; ctl_wbit = 1; @(negedge clk); ctl_we = 0;
    chk("R3 gated at boundary", core_ce, 0);
    chk("R11 idle_active set", idle_active, 1);

    // R3: gating waits for boundary
    enter_idle();
    chk("R3 exact gating", core_ce, 0);

    // R5: exact wake timing
    enter_idle();
    @(negedge clk);
    irq_req = 8'h04; irq_en = 8'h04; gie = 1;
    @(negedge clk);
    irq_req = 0; irq_en = 0; gie = 0;
    chk("R5 bit cleared", ctl_rbit, 0); chk("R5 ce still low", core_ce, 0);
    @(negedge clk); chk("R5 ce waits boundary", core_ce, 0);
    @(negedge clk); chk("R5 ce restored", core_ce, 1);

    // R10: wake beats write
    enter_idle();
    irq_req = 8'h10; irq_en = 8'h10; gie = 1; ctl_we = 1; ctl_wbit = 1;
    @(negedge clk);
    irq_req = 0; irq_en = 0; gie = 0; ctl_we = 0;
    chk("R10 wake wins", ctl_rbit, 0);
    repeat (3) @(negedge clk);
    chk("R10 ce back", core_ce, 1);

    // R7: exact restart hold
    repeat (20) @(negedge clk);
    rst_lvd = 1; @(negedge clk); rst_lvd = 0;
    chk("R7 ce on", core_ce, 1);
    count_rst(n);
    chk("R7 hold length", n, 12);

    // R9: watchdog while running
    align();
    rst_wdt = 1; @(negedge clk); rst_wdt = 0;
    count_rst(n);
    chk("R9 wdt hold length", n, 12);

    // R2: write and read back
    align();
    ctl_we = 1; ctl_wbit = 1; @(negedge clk);
    chk("R2 set reads 1", ctl_rbit, 1);
    ctl_wbit = 0; @(negedge clk); ctl_we = 0;
    chk("R2 clear reads 0", ctl_rbit, 0);
    repeat (3) @(negedge clk);
    chk("R2 cleared bit no gating", core_ce, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    nerr++; nchk++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule